// File: doc/BRIEF.md
# Framed Serial Sample Receiver

This block takes the three lines of a gated-clock serial link into a fast system clock: a serial clock, a frame-sync line and a data line. The serial clock runs only while a frame is on the wire. It stays low between frames and also stays low during the sync pulse. A frame opens with a sync pulse one serial period wide. On its falling edge the receiver arms, and it then samples data on each of the 96 rising serial-clock edges that follow. The 96 bits form six 16-bit words, each sent most significant bit first. The first word is a voltage sample and the second is a current sample. The remaining four words are padding and must read as zero.

All three lines pass through two-stage synchronizers. Their edges are then found in the system clock domain, which must run at least four times faster than the serial clock. When a frame completes, the two sample words appear together with a one-cycle valid strobe. A padding flag accompanies that strobe if any padding bit was one. If the sync line rises again before the 96th bit, the block raises a one-cycle framing-error strobe, drops the partial frame and arms again on the new sync pulse.

The controller has three states. `ST_IDLE` waits for a sync rise and goes to `ST_SYNC`. `ST_SYNC` waits for the sync fall, clears the bit counter and goes to `ST_RECV`. `ST_RECV` shifts one bit on each serial-clock rise. It returns to `ST_IDLE` after the 96th bit (completion). It goes back to `ST_SYNC` if a sync rise arrives first (framing error).

Top module: `sfrm_rx`

## Requirements
- R1: While reset is held and after it is released, `frame_valid`, `pad_err` and `frame_err` are 0 and both sample words are 0x0000, until a frame completes.
- R2: A frame is accepted only after a sync-line high pulse followed by its falling edge. Serial-clock rises seen before any sync pulse produce no `frame_valid`.
- R3: The first 16 bits after the sync fall, MSB first, appear on `volt_word`. Bits 17 to 32 appear on `curr_word`.
- R4: A complete frame of 96 serial-clock rises gives exactly one `frame_valid` pulse, one system cycle wide, no more than 8 system cycles after the 96th rise.
- R5: `pad_err` is 1 in the `frame_valid` cycle exactly when any of bits 33 to 96 was 1, including the very last bit. It is 0 in every other cycle.
- R6: A sync rise after the sync fall and before the 96th bit gives one `frame_err` pulse, one cycle wide, and no `frame_valid` for that frame. The frame opened by that sync pulse is then captured correctly.
- R7: Serial-clock rises that arrive after a frame has completed and before the next sync pulse do not change the outputs.
- R8: `volt_word` and `curr_word` change only in a cycle where `frame_valid` is 1.
- R9: Two frames sent back to back, separated only by the sync pulse, are both captured, each with its own `frame_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Gated serial clock, asynchronous |
| ser_sync | input | 1 | Frame-sync line, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| volt_word | output | 16 | Captured first word (voltage) |
| curr_word | output | 16 | Captured second word (current) |
| frame_valid | output | 1 | One-cycle strobe when a frame completes |
| pad_err | output | 1 | Padding contained a one; valid with `frame_valid` |
| frame_err | output | 1 | One-cycle strobe on a truncated frame |

## Verification
Completion and the padding check meet in one cycle when the only non-zero padding bit is the 96th bit. That bit is shifted in during the same cycle that finishes the frame, so it has to reach `pad_err` through the completion path, not through the accumulated flag. The bench sends a frame whose last bit alone is one. It expects `pad_err` high exactly in the `frame_valid` cycle, with the sample words intact. A second frame carries a one only in the first padding bit, and a third has clean padding; together they show that the flag is neither missed nor left set from an earlier frame.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RECV = 2'd2
    } rx_state_t;

    // Line indices into the synchronizer bank
    localparam int LN_CLK  = 0;
    localparam int LN_SYNC = 1;
    localparam int LN_DAT  = 2;
    localparam int N_LINES = 3;

endpackage

// File: rtl/sfrm_sync.sv
module sfrm_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                    prev  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~prev;
            assign fall[g] = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/sfrm_fsm.sv
module sfrm_fsm
    import sfrm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise,
    input  logic sync_fall,
    input  logic sclk_rise,
    input  logic last_bit,
    output logic clr,
    output logic shift_en,
    output logic done,
    output logic ferr
);

    rx_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (sync_rise) state_nx = ST_SYNC;
            ST_SYNC: if (sync_fall) state_nx = ST_RECV;
            ST_RECV: begin
                if (sync_rise)                 state_nx = ST_SYNC;
                else if (sclk_rise && last_bit) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        clr      = 1'b0;
        shift_en = 1'b0;
        done     = 1'b0;
        ferr     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SYNC: clr = sync_fall;
            ST_RECV: begin
                if (sync_rise) begin
                    ferr = 1'b1;
                end else if (sclk_rise) begin
                    shift_en = 1'b1;
                    done     = last_bit;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sfrm_dpath.sv
module sfrm_dpath #(
    parameter int WORD_W    = 16,
    parameter int PAD_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              done,
    input  logic              ferr,
    input  logic              bit_in,
    output logic              last_bit,
    output logic [WORD_W-1:0] volt_word,
    output logic [WORD_W-1:0] curr_word,
    output logic              frame_valid,
    output logic              pad_err,
    output logic              frame_err
);

    localparam int KEEP_BITS  = 2 * WORD_W;
    localparam int TOTAL_BITS = (2 + PAD_WORDS) * WORD_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS);

    logic [CNT_W-1:0]     bit_cnt;
    logic [KEEP_BITS-1:0] shreg;
    logic                 pad_acc;
    logic                 in_keep;

    assign last_bit = (bit_cnt == CNT_W'(TOTAL_BITS - 1));
    assign in_keep  = (bit_cnt < CNT_W'(KEEP_BITS));

    // Bit counter, sample shifter, padding accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            pad_acc <= 1'b0;
        end else if (clr) begin
            bit_cnt <= '0;
            pad_acc <= 1'b0;
        end else if (shift_en) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (in_keep) shreg   <= {shreg[KEEP_BITS-2:0], bit_in};
            else         pad_acc <= pad_acc | bit_in;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            volt_word   <= '0;
            curr_word   <= '0;
            frame_valid <= 1'b0;
            pad_err     <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            frame_valid <= done;
            pad_err     <= done & (pad_acc | bit_in);
            frame_err   <= ferr;
            if (done) begin
                volt_word <= shreg[KEEP_BITS-1:WORD_W];
                curr_word <= shreg[WORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sfrm_rx.sv
module sfrm_rx
    import sfrm_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PAD_WORDS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sync,
    input  logic              ser_dat,
    output logic [WORD_W-1:0] volt_word,
    output logic [WORD_W-1:0] curr_word,
    output logic              frame_valid,
    output logic              pad_err,
    output logic              frame_err
);

    logic [N_LINES-1:0] lvl, rise, fall;
    logic clr, shift_en, done, ferr, last_bit;

    sfrm_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_dat, ser_sync, ser_clk}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    sfrm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rise(rise[LN_SYNC]),
        .sync_fall(fall[LN_SYNC]),
        .sclk_rise(rise[LN_CLK]),
        .last_bit (last_bit),
        .clr      (clr),
        .shift_en (shift_en),
        .done     (done),
        .ferr     (ferr)
    );

    sfrm_dpath #(.WORD_W(WORD_W), .PAD_WORDS(PAD_WORDS)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .shift_en   (shift_en),
        .done       (done),
        .ferr       (ferr),
        .bit_in     (lvl[LN_DAT]),
        .last_bit   (last_bit),
        .volt_word  (volt_word),
        .curr_word  (curr_word),
        .frame_valid(frame_valid),
        .pad_err    (pad_err),
        .frame_err  (frame_err)
    );

endmodule

// File: rtl/sfrm_rx_chk.sv
module sfrm_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] volt_word,
    input logic [WORD_W-1:0] curr_word,
    input logic              frame_valid,
    input logic              pad_err,
    input logic              frame_err
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!frame_valid && !pad_err && !frame_err && volt_word == '0 && curr_word == '0));

    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r5_pad_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pad_err |-> frame_valid);

    a_r6_ferr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r6_ferr_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !frame_valid);

    a_r8_volt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(volt_word));

    a_r8_curr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(curr_word));

endmodule

bind sfrm_rx sfrm_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .volt_word  (volt_word),
    .curr_word  (curr_word),
    .frame_valid(frame_valid),
    .pad_err    (pad_err),
    .frame_err  (frame_err)
);

// File: tb/sfrm_rx_test.sv
module sfrm_rx_test;

    localparam int CLK_P = 10;
    localparam int HALF  = 4;   // system cycles per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sync = 1'b0, ser_dat = 1'b0;
    logic [15:0] volt_word, curr_word;
    logic frame_valid, pad_err, frame_err;

    int n_chk = 0, n_err = 0;
    int n_valid = 0, n_ferr = 0, n_pad = 0, n_dbl = 0;
    logic [15:0] last_v = '0, last_c = '0;
    logic prev_v = 1'b0, prev_f = 1'b0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sfrm_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_dat(ser_dat),
        .volt_word(volt_word), .curr_word(curr_word),
        .frame_valid(frame_valid), .pad_err(pad_err), .frame_err(frame_err)
    );

    // Monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (frame_valid) begin
            n_valid++;
            last_v = volt_word;
            last_c = curr_word;
            if (pad_err) n_pad++;
        end
        if (frame_err) n_ferr++;
        if ((frame_valid && prev_v) || (frame_err && prev_f)) n_dbl++;
        if (pad_err && !frame_valid) n_dbl++;
        prev_v = frame_valid;
        prev_f = frame_err;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic sync_pulse();
        ser_sync = 1'b1;
        idle(2 * HALF);
        ser_sync = 1'b0;
        idle(HALF);
    endtask

    task automatic send_bits(input logic [95:0] fr, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b0;
            ser_dat = fr[95 - i];
            idle(HALF);
            ser_clk = 1'b1;
            idle(HALF);
        end
        ser_clk = 1'b0;
        ser_dat = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] v, input logic [15:0] c, input logic [63:0] pad);
        sync_pulse();
        send_bits({v, c, pad}, 96);
    endtask

    task automatic t_reset();
        idle(4);
        chk(!frame_valid && !pad_err && !frame_err, "R1 flags in reset", {frame_valid, pad_err, frame_err}, 0);
        chk(volt_word == 0 && curr_word == 0, "R1 words in reset", {volt_word, curr_word}, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(6);
        @(negedge clk);
        chk(!frame_valid && !frame_err && volt_word == 0, "R1 after release", {frame_valid, frame_err, volt_word}, 0);
    endtask

    task automatic t_no_sync();
        int v0 = n_valid;
        send_bits({16'hFFFF, 16'hFFFF, 64'h0}, 96);
        idle(12);
        chk(n_valid == v0, "R2 clocks without sync", n_valid - v0, 0);
        chk(volt_word == 0, "R2 word untouched", volt_word, 0);
    endtask

    task automatic t_frame(input logic [15:0] v, input logic [15:0] c, input logic [63:0] pad, input string tag);
        int v0 = n_valid;
        int p0 = n_pad;
        int dl = 0;
        logic exp_pad = |pad;
        sync_pulse();
        send_bits({v, c, pad}, 95);
        ser_clk = 1'b0;
        ser_dat = pad[0];
        idle(HALF);
        ser_clk = 1'b1;
        while (n_valid == v0 && dl < 20) begin
            @(negedge clk);
            dl++;
        end
        ser_clk = 1'b0;
        ser_dat = 1'b0;
        idle(12);
        chk(n_valid - v0 == 1, {"R4 one valid ", tag}, n_valid - v0, 1);
        chk(dl <= 8, {"R4 latency ", tag}, dl, 8);
        chk(last_v == v, {"R3 volt ", tag}, last_v, v);
        chk(last_c == c, {"R3 curr ", tag}, last_c, c);
        chk((n_pad - p0) == int'(exp_pad), {"R5 pad flag ", tag}, n_pad - p0, exp_pad);
    endtask

    task automatic t_stray();
        logic [15:0] v0 = volt_word, c0 = curr_word;
        int n0 = n_valid;
        send_bits({96{1'b1}}, 40);
        idle(12);
        chk(n_valid == n0, "R7 stray clocks no valid", n_valid - n0, 0);
        chk(volt_word == v0 && curr_word == c0, "R7 words held", {volt_word, curr_word}, {v0, c0});
    endtask

    task automatic t_short();
        int v0 = n_valid, f0 = n_ferr;
        sync_pulse();
        send_bits({16'hDEAD, 16'hBEEF, 64'h0}, 40);
        idle(2);
        chk(n_valid == v0, "R6 no valid for partial", n_valid - v0, 0);
        send_frame(16'h1357, 16'h2468, 64'h0);
        idle(12);
        chk(n_ferr - f0 == 1, "R6 one frame_err", n_ferr - f0, 1);
        chk(n_valid - v0 == 1, "R6 next frame valid", n_valid - v0, 1);
        chk(last_v == 16'h1357 && last_c == 16'h2468, "R6 next frame words", {last_v, last_c}, 32'h13572468);
    endtask

    task automatic t_b2b();
        int v0 = n_valid;
        send_frame(16'h0F0F, 16'hF0F0, 64'h0);
        send_frame(16'h8001, 16'h7FFE, 64'h0);
        idle(12);
        chk(n_valid - v0 == 2, "R9 two valids", n_valid - v0, 2);
        chk(last_v == 16'h8001 && last_c == 16'h7FFE, "R9 second words", {last_v, last_c}, 32'h80017FFE);
    endtask

    initial begin
        t_reset();
        t_no_sync();
        t_frame(16'hA5C3, 16'h3C5A, 64'h0, "clean");
        t_frame(16'h1234, 16'hFEDC, 64'h1, "last bit");
        t_frame(16'h0001, 16'h8000, 64'h8000_0000_0000_0000, "first pad bit");
        t_frame(16'hFFFF, 16'h0000, 64'h0, "clean after pad");
        t_stray();
        t_short();
        t_b2b();
        chk(n_dbl == 0, "R4 R5 R6 strobe shape", n_dbl, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule